// File: doc/BRIEF.md
# Ping-Pong Audio Sample Streamer

This block feeds a serial audio transmitter from two equal-size sample buffers held in an external synchronous memory, with no processor involvement per sample. Two channels take turns. The active channel fetches one 16-bit sample from its own buffer each time the transmitter requests data. The fetched sample is then presented on the output with a one-cycle valid strobe. The destination is a single fixed register, so the sample width is also the transfer unit.

When the active channel has read the last sample of its buffer, it switches itself off and arms the other channel. It also raises a sticky done flag for the buffer it has just drained, which signals software that the buffer may be refilled. The flag stays set until software writes a one to clear it. Playback alternates between the buffers without end for as long as the global enable stays high. Dropping the enable halts both channels and rewinds both read pointers. Raising it again always restarts on channel 0.

Top module: `pingpong_streamer`

## Requirements
- R1: While reset is asserted and immediately after it, `mem_rd_en`, `sample_valid`, `done_flag` and `ch_active` are all zero, and `sample_data` is zero.
- R2: One clock edge after `enable` is seen high with no channel running, `ch_active` becomes 2'b01 (channel 0 runs first, channel 1 stays off). A request is accepted from the next cycle on.
- R3: A request accepted at a clock edge drives `mem_rd_en` high in that same cycle, with `mem_rd_addr` = {channel, index}: bit 6 selects the buffer (0 or 1) and bits 5:0 hold the sample index. The read data is expected one edge later, and in the cycle after the accepting edge `sample_valid` is high for exactly one cycle with `sample_data` equal to the word read.
- R4: Within a channel the index starts at 0 and advances by one per accepted request. The request that reads index `buf_len`-1 is the last for that channel. After that edge, the channel is off and the other channel is on at index 0. The next request reads the other buffer, with no sample skipped or repeated.
- R5: `done_flag[c]` is set at the edge where channel c reads its last sample, and then stays set until an edge at which `done_clr[c]` is 1. A clear affects only its own bit. A completion at the same edge as a clear of the same bit leaves the flag set.
- R6: While `enable` is low, `tx_req` is ignored: `mem_rd_en` stays 0 and no `sample_valid` follows.
- R7: Lowering `enable` turns both channels off (`ch_active` = 0) at the next edge and rewinds both indices. After re-enable, the first sample comes from buffer 0, index 0, whatever the position was before. Done flags are kept across the disable.
- R8: `buf_len` sets the number of samples per buffer, from 1 up to MAX_LEN (64 by default). With length 1, the channels alternate on every request.
- R9: At most one channel is ever active. After one edge with `enable` high, exactly one channel is active for as long as `enable` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global run control |
| buf_len | input | 7 | Samples per buffer (1..MAX_LEN) |
| tx_req | input | 1 | Transmitter can take one sample this cycle |
| done_clr | input | 2 | Write-one-to-clear for the per-buffer done flags |
| mem_rd_data | input | 16 | Sample returned by memory one edge after a read |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 7 | {buffer select, sample index} |
| sample_valid | output | 1 | Sample on `sample_data` is to be taken this cycle |
| sample_data | output | 16 | Sample for the transmitter |
| done_flag | output | 2 | Sticky per-buffer completion interrupt flags |
| ch_active | output | 2 | Which channel currently owns the stream |

## Verification
The memory read and its address appear in the same cycle as the request. Sample data, the valid strobe, the done flag and the channel switch all become visible just after the edge that accepts that request. Enable takes effect one edge after it changes. The bench drives inputs on falling edges and samples every output on the falling edge that follows the accepting rising edge. At that point it checks the sample, the valid strobe and both done flags against a counter model that tracks channel, index and pending clears for each buffer length in the sweep.

// File: rtl/pingpong_streamer.sv
module pingpong_streamer #(
  parameter int SAMPLE_W = 16,
  parameter int MAX_LEN  = 64,
  localparam int IDX_W   = $clog2(MAX_LEN),
  localparam int LEN_W   = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [LEN_W-1:0]    buf_len,
  input  logic                tx_req,
  input  logic [1:0]          done_clr,
  input  logic [SAMPLE_W-1:0] mem_rd_data,
  output logic                mem_rd_en,
  output logic [IDX_W:0]      mem_rd_addr,
  output logic                sample_valid,
  output logic [SAMPLE_W-1:0] sample_data,
  output logic [1:0]          done_flag,
  output logic [1:0]          ch_active
);

  logic [1:0]            ch_en;
  logic [1:0][IDX_W-1:0] ptr;
  logic                  valid_q;

  wire             sel     = ch_en[1];
  wire [IDX_W-1:0] cur_ptr = ptr[sel];
  wire             fire    = enable & tx_req & (|ch_en);
  wire             last    = ({1'b0, cur_ptr} == (buf_len - LEN_W'(1)));
  wire [1:0]       finish  = {2{fire & last}} & ch_en;

  assign mem_rd_en    = fire;
  assign mem_rd_addr  = {sel, cur_ptr};
  assign sample_valid = valid_q;
  assign sample_data  = valid_q ? mem_rd_data : '0;
  assign ch_active    = ch_en;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable)   ch_en <= 2'b00;
    else if (ch_en == 2'b00) ch_en <= 2'b01;
    else if (fire && last)   ch_en <= {ch_en[0], ch_en[1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= fire;
  end

  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic [IDX_W-1:0] p_q;
    logic             d_q;

    always_ff @(posedge clk) begin
      if (!rst_n || !enable)      p_q <= '0;
      else if (finish[g])         p_q <= '0;
      else if (fire && ch_en[g])  p_q <= p_q + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)           d_q <= 1'b0;
      else if (finish[g])   d_q <= 1'b1;
      else if (done_clr[g]) d_q <= 1'b0;
    end

    assign ptr[g]       = p_q;
    assign done_flag[g] = d_q;
  end

endmodule

// File: rtl/pingpong_streamer_chk.sv
module pingpong_streamer_chk #(
  parameter int MAX_LEN  = 64,
  localparam int IDX_W   = $clog2(MAX_LEN),
  localparam int LEN_W   = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [LEN_W-1:0] buf_len,
  input logic [1:0]       done_clr,
  input logic             mem_rd_en,
  input logic [IDX_W:0]   mem_rd_addr,
  input logic             sample_valid,
  input logic [1:0]       done_flag,
  input logic [1:0]       ch_active
);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (done_flag == 2'b00 && ch_active == 2'b00 && !sample_valid));

  p_start_ch0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ch_active == 2'b00) |=> (!enable || ch_active == 2'b01));

  p_valid_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> sample_valid);

  p_no_spurious_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_en |=> !sample_valid);

  p_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && ({1'b0, mem_rd_addr[IDX_W-1:0]} == buf_len - LEN_W'(1)))
    |=> (done_flag[$past(mem_rd_addr[IDX_W])] && !ch_active[$past(mem_rd_addr[IDX_W])]));

  p_done0_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag[0] && !done_clr[0]) |=> done_flag[0]);

  p_done1_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag[1] && !done_clr[1]) |=> done_flag[1]);

  p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !mem_rd_en);

  p_off_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ch_active == 2'b00);

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_active));

  p_one_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(rst_n)) |-> $countones(ch_active) == 1);

endmodule

bind pingpong_streamer pingpong_streamer_chk #(.MAX_LEN(MAX_LEN)) u_chk (.*);

// File: tb/tb_pingpong_streamer.sv
`timescale 1ns/1ps
module tb_pingpong_streamer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [6:0]  buf_len = 7'd64;
  logic        tx_req = 1'b0;
  logic [1:0]  done_clr = 2'b00;
  logic [15:0] mem_rd_data = 16'h0;
  logic        mem_rd_en;
  logic [6:0]  mem_rd_addr;
  logic        sample_valid;
  logic [15:0] sample_data;
  logic [1:0]  done_flag;
  logic [1:0]  ch_active;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_ch = 0;
  int m_idx = 0;
  int m_len = 64;
  logic [1:0] m_done = 2'b00;

  always #4 clk = ~clk;

  pingpong_streamer dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .buf_len(buf_len),
    .tx_req(tx_req), .done_clr(done_clr), .mem_rd_data(mem_rd_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .sample_valid(sample_valid), .sample_data(sample_data),
    .done_flag(done_flag), .ch_active(ch_active)
  );

  function automatic logic [15:0] pattern(input logic ch, input logic [5:0] idx);
    return ch ? (16'hA000 + 16'(idx) * 16'd7) : (16'h3000 + 16'(idx) * 16'd5 + 16'd1);
  endfunction

  always_ff @(posedge clk)
    if (mem_rd_en) mem_rd_data <= pattern(mem_rd_addr[6], mem_rd_addr[5:0]);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input int n, input logic [1:0] clr, input string tag);
    logic [15:0] exp_d;
    logic [1:0]  fin;
    @(negedge clk);
    tx_req   = 1'b1;
    done_clr = clr;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      exp_d = pattern(m_ch[0], 6'(m_idx));
      fin   = 2'b00;
      m_idx++;
      if (m_idx == m_len) begin
        fin   = (m_ch == 0) ? 2'b01 : 2'b10;
        m_ch  = 1 - m_ch;
        m_idx = 0;
      end
      m_done = (m_done & ~clr) | fin;
      @(negedge clk);
      check({tag, " valid"}, 32'(sample_valid), 32'd1);
      check({tag, " data"}, 32'(sample_data), 32'(exp_d));
      check({tag, " done"}, 32'(done_flag), 32'(m_done));
    end
    tx_req   = 1'b0;
    done_clr = 2'b00;
  endtask

  task automatic enable_on(input int len);
    @(negedge clk);
    buf_len = 7'(len);
    m_len   = len;
    enable  = 1'b1;
    @(negedge clk);
    check("R2 channel 0 first", 32'(ch_active), 32'd1);
  endtask

  task automatic disable_off();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    m_ch = 0;
    m_idx = 0;
    check("R7 both channels off", 32'(ch_active), 32'd0);
    check("R7 done kept", 32'(done_flag), 32'(m_done));
  endtask

  task automatic clear_all();
    @(negedge clk);
    done_clr = 2'b11;
    @(negedge clk);
    done_clr = 2'b00;
    m_done = 2'b00;
    check("R5 clear both", 32'(done_flag), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens [5] = '{1, 2, 3, 5, 64};
    repeat (4) @(negedge clk);
    check("R1 valid in reset", 32'(sample_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", 32'(sample_valid), 32'd0);
    check("R1 data", 32'(sample_data), 32'd0);
    check("R1 done", 32'(done_flag), 32'd0);
    check("R1 active", 32'(ch_active), 32'd0);
    check("R1 read", 32'(mem_rd_en), 32'd0);

    tx_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 no read while off", 32'(mem_rd_en), 32'd0);
      check("R6 no valid while off", 32'(sample_valid), 32'd0);
    end
    tx_req = 1'b0;

    foreach (lens[k]) begin
      enable_on(lens[k]);
      do_req(lens[k] + 1, 2'b00, "R4 burst handover");
      for (int j = 0; j < 2 * lens[k] + 1; j++) begin
        do_req(1, (j % 4 == 3) ? 2'b11 : 2'b00, "R8 sweep single");
        if (j == 0) begin
          @(negedge clk);
          check("R3 one-cycle valid", 32'(sample_valid), 32'd0);
        end
      end
      disable_off();
      clear_all();
    end

    enable_on(1);
    do_req(1, 2'b01, "R5 set beats clear");
    do_req(1, 2'b01, "R5 clear own bit only");
    disable_off();
    clear_all();

    enable_on(5);
    do_req(7, 2'b00, "R4 into buffer 1");
    disable_off();
    @(negedge clk);
    tx_req = 1'b1;
    @(negedge clk);
    check("R6 ignored after disable", 32'(sample_valid), 32'd0);
    tx_req = 1'b0;
    enable_on(5);
    do_req(1, 2'b00, "R7 restart at buffer 0 index 0");
    do_req(5, 2'b00, "R7 restart run");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule